// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block sits between a host-side configuration address register plus data window and a downstream PCI-style configuration access port. Software first writes a 32-bit selector word into the address register. Each later access to the data window turns that word and the low three bits of the window offset into a standard configuration address. The access is then issued downstream with a byte-enable mask and a one-cycle strobe.

The host is big-endian and the configuration bus is little-endian. Write data is therefore byte-swapped according to the access size on its way down, and read data is swapped the same way on its way back.

A selector word without bit 31 and with both low bits clear names its target with a one-hot slot field. The block finds the lowest set bit of that field and turns it into a binary device number. When the field is empty, the access is refused.

The block also folds the four interrupt pins of every attached device onto four shared interrupt lines. The rotation depends on the device number.

Top module: `cfg_addr_xlate`

## Requirements
- R1: The address register is zero after reset. It loads `reg_wdata` on a clock where `reg_wr` is high, keeps its value otherwise, and is always visible unchanged on `cfg_word`.
- R2: When bit 31 of the stored word is set, the translated address is the stored word with bits 1:0 replaced by `win_off[1:0]`.
- R3: When bit 31 is clear and bits 1:0 of the word are not both zero, the translated address is the word with bits 2:0 cleared, ORed with `win_off[2:0]`.
- R4: When bits 31 and 1:0 are all clear, the translated address has these fields: bits 31:16 zero; bits 15:11 equal to (index of the lowest set bit among word bits 30:11) minus 11; bits 10:8 equal to word bits 10:8; bits 7:3 equal to word bits 7:3; bits 2:0 equal to `win_off`.
- R5: In the R4 case with no set bit in word bits 30:11, the access is invalid. No strobe is issued. A read answers with `host_rvalid` and `host_rdata` = 0xFFFFFFFF one cycle after the request. A write is dropped.
- R6: A valid request on `win_req` produces `cfg_stb` for exactly one cycle, one clock later. `cfg_addr`, `cfg_be`, `cfg_wdata` are presented with it, and `cfg_we` equals the request's `win_write`.
- R7: The size code on `win_size` selects the byte enables. 00 (1 byte) gives `4'b0001 << win_off[1:0]`. 01 (2 bytes) gives 4'b0011 if `win_off[1]` is 0, else 4'b1100. 10 and 11 (4 bytes) give 4'b1111.
- R8: `cfg_wdata` is `win_wdata` byte-swapped by size. For size 00 it is bits 7:0, zero-extended. For size 01 it is {16'b0, bits 7:0, bits 15:8}. For 4 bytes it is the full byte reversal.
- R9: A high `cfg_rvalid` gives `host_rvalid` one clock later. `host_rdata` is `cfg_rdata` swapped as in R8, using the size of the most recent window request.
- R10: Device slot s (device number SLOT0+s) drives pin n (0 = INTA to 3 = INTD) on `dev_intx[4*s+n]`. `irq_line[k]` is the OR of all pins with (SLOT0+s+n) mod 4 = k, without any clock delay. Line k is meant for interrupt controller input 0x1B+k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_wr | input | 1 | Write strobe for the address register |
| reg_wdata | input | 32 | New selector word |
| cfg_word | output | 32 | Stored selector word, for read-back |
| win_req | input | 1 | Data window access request (one cycle) |
| win_write | input | 1 | 1 = write, 0 = read |
| win_off | input | 3 | Low bits of the data window offset |
| win_size | input | 2 | Access size code (00 = 1, 01 = 2, 1x = 4 bytes) |
| win_wdata | input | 32 | Host write data, right-justified, big-endian |
| host_rvalid | output | 1 | Read data valid to host |
| host_rdata | output | 32 | Read data to host, swapped back |
| cfg_stb | output | 1 | Downstream access strobe |
| cfg_we | output | 1 | Downstream write flag |
| cfg_addr | output | 32 | Translated configuration address |
| cfg_be | output | 4 | Downstream byte enables |
| cfg_wdata | output | 32 | Downstream write data, little-endian |
| cfg_rvalid | input | 1 | Downstream read data valid |
| cfg_rdata | input | 32 | Downstream read data |
| dev_intx | input | 4*NSLOT | Device interrupt pins, four per slot |
| irq_line | output | 4 | Swizzled interrupt lines |

## Verification
The request path has one register stage. A window request sampled on a rising edge shows `cfg_stb` and its fields, or for a refused read the all-ones reply, after that same edge. A `cfg_rvalid` beat shows up on `host_rvalid` after the edge that samples it. Register writes appear on `cfg_word` after the sampling edge, while the interrupt lines follow their inputs with no delay.

The reference model updates its expected values on each rising edge from the inputs it saw there. The outputs are compared at the following falling edge, so every check lands exactly one register delay after its stimulus, and the interrupt lines are compared on that same falling edge.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;
  localparam int WORD_W   = 32;
  localparam int SLOT_LSB = 11;
  localparam int SLOT_MSB = 30;
  localparam int SLOT_W   = 16 - SLOT_LSB;
  localparam int LANES    = WORD_W / 8;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_WORD2 = 2'b11
  } acc_size_e;
endpackage

// File: rtl/cfg_addr_map.sv
module cfg_addr_map
  import cfg_xlate_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [2:0]        off,
  output logic [WORD_W-1:0] addr,
  output logic              ok
);
  logic [SLOT_W-1:0] slot;
  logic              hit;

  // lowest set bit of the one-hot slot field; scanning downward lets the lowest win
  always_comb begin
    slot = '0;
    hit  = 1'b0;
    for (int i = SLOT_MSB; i >= SLOT_LSB; i--) begin
      if (word[i]) begin
        slot = SLOT_W'(i - SLOT_LSB);
        hit  = 1'b1;
      end
    end
  end

  always_comb begin
    if (word[31]) begin
      addr = {word[31:2], off[1:0]};
      ok   = 1'b1;
    end else if (word[1:0] != 2'b00) begin
      addr = {word[31:3], off};
      ok   = 1'b1;
    end else begin
      addr = {16'h0000, slot, word[10:8], word[7:3], off};
      ok   = hit;
    end
  end
endmodule

// File: rtl/cfg_lane_swap.sv
module cfg_lane_swap
  import cfg_xlate_pkg::*;
(
  input  logic [1:0]        size,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);
  logic [WORD_W-1:0] rev;

  for (genvar b = 0; b < LANES; b++) begin : g_rev
    assign rev[8*b +: 8] = din[8*(LANES-1-b) +: 8];
  end

  always_comb begin
    unique case (acc_size_e'(size))
      SZ_BYTE: dout = {24'h0, din[7:0]};
      SZ_HALF: dout = {16'h0, din[7:0], din[15:8]};
      default: dout = rev;
    endcase
  end
endmodule

// File: rtl/cfg_irq_swizzle.sv
module cfg_irq_swizzle #(
  parameter int NSLOT = 4,
  parameter int SLOT0 = 11
) (
  input  logic [4*NSLOT-1:0] pins,
  output logic [3:0]         lines
);
  for (genvar k = 0; k < 4; k++) begin : g_line
    logic acc;
    always_comb begin
      acc = 1'b0;
      for (int s = 0; s < NSLOT; s++) begin
        for (int n = 0; n < 4; n++) begin
          if (((SLOT0 + s + n) % 4) == k) acc = acc | pins[4*s+n];
        end
      end
    end
    assign lines[k] = acc;
  end
endmodule

// File: rtl/cfg_addr_xlate.sv
module cfg_addr_xlate
  import cfg_xlate_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int SLOT0 = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        cfg_word,
  input  logic               win_req,
  input  logic               win_write,
  input  logic [2:0]         win_off,
  input  logic [1:0]         win_size,
  input  logic [31:0]        win_wdata,
  output logic               host_rvalid,
  output logic [31:0]        host_rdata,
  output logic               cfg_stb,
  output logic               cfg_we,
  output logic [31:0]        cfg_addr,
  output logic [3:0]         cfg_be,
  output logic [31:0]        cfg_wdata,
  input  logic               cfg_rvalid,
  input  logic [31:0]        cfg_rdata,
  input  logic [4*NSLOT-1:0] dev_intx,
  output logic [3:0]         irq_line
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [31:0] word_q, word_d;
  logic        stb_q, stb_d, we_q, we_d, rv_q, rv_d;
  logic [31:0] addr_q, addr_d, wd_q, wd_d, rd_q, rd_d;
  logic [3:0]  be_q, be_d;
  logic [1:0]  size_q, size_d;
  logic [31:0] map_addr, wr_swapped, rd_swapped;
  logic        map_ok, go, bad_rd;
  logic [3:0]  be_calc;

  cfg_addr_map u_map (.word(word_q), .off(win_off), .addr(map_addr), .ok(map_ok));
  cfg_lane_swap u_wswap (.size(win_size), .din(win_wdata), .dout(wr_swapped));
  cfg_lane_swap u_rswap (.size(size_q), .din(cfg_rdata), .dout(rd_swapped));
  cfg_irq_swizzle #(.NSLOT(NSLOT), .SLOT0(SLOT0)) u_irq (.pins(dev_intx), .lines(irq_line));

  always_comb begin
    unique case (acc_size_e'(win_size))
      SZ_BYTE: be_calc = 4'b0001 << win_off[1:0];
      SZ_HALF: be_calc = win_off[1] ? 4'b1100 : 4'b0011;
      default: be_calc = 4'b1111;
    endcase
  end

  assign go     = win_req & map_ok;
  assign bad_rd = win_req & ~win_write & ~map_ok;

  always_comb begin
    word_d = reg_wr  ? reg_wdata  : word_q;
    stb_d  = go;
    we_d   = go      ? win_write  : we_q;
    addr_d = go      ? map_addr   : addr_q;
    be_d   = go      ? be_calc    : be_q;
    wd_d   = go      ? wr_swapped : wd_q;
    size_d = win_req ? win_size   : size_q;
    rv_d   = cfg_rvalid | bad_rd;
    if (cfg_rvalid)  rd_d = rd_swapped;
    else if (bad_rd) rd_d = '1;
    else             rd_d = rd_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      word_q <= '0;
      stb_q  <= 1'b0;
      we_q   <= 1'b0;
      addr_q <= '0;
      be_q   <= '0;
      wd_q   <= '0;
      size_q <= '0;
      rv_q   <= 1'b0;
      rd_q   <= '0;
    end else begin
      word_q <= word_d;
      stb_q  <= stb_d;
      we_q   <= we_d;
      addr_q <= addr_d;
      be_q   <= be_d;
      wd_q   <= wd_d;
      size_q <= size_d;
      rv_q   <= rv_d;
      rd_q   <= rd_d;
    end
  end

  assign cfg_word    = word_q;
  assign cfg_stb     = stb_q;
  assign cfg_we      = we_q;
  assign cfg_addr    = addr_q;
  assign cfg_be      = be_q;
  assign cfg_wdata   = wd_q;
  assign host_rvalid = rv_q;
  assign host_rdata  = rd_q;
endmodule

// File: rtl/cfg_addr_xlate_chk.sv
module cfg_addr_xlate_chk #(
  parameter int NSLOT = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic [31:0]        cfg_word,
  input logic               win_req,
  input logic               win_write,
  input logic [1:0]         win_size,
  input logic               cfg_stb,
  input logic               cfg_we,
  input logic [3:0]         cfg_be,
  input logic               cfg_rvalid,
  input logic               host_rvalid,
  input logic [31:0]        host_rdata,
  input logic [4*NSLOT-1:0] dev_intx,
  input logic [3:0]         irq_line
);
  a_r1_word_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(cfg_word));

  a_r6_stb_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_stb |-> $past(win_req));

  a_r6_we_mirrors: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_stb |-> (cfg_we == $past(win_write)));

  a_r7_be_count: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_stb |-> ($countones(cfg_be) ==
                 (($past(win_size) == 2'b00) ? 1 : ($past(win_size) == 2'b01) ? 2 : 4)));

  a_r5_refused_read_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rvalid && !$past(cfg_rvalid)) |-> (host_rdata == 32'hFFFF_FFFF));

  a_r10_quiet_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_intx == '0) |-> (irq_line == 4'b0000));
endmodule

bind cfg_addr_xlate cfg_addr_xlate_chk #(.NSLOT(NSLOT)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .cfg_word(cfg_word),
  .win_req(win_req), .win_write(win_write), .win_size(win_size),
  .cfg_stb(cfg_stb), .cfg_we(cfg_we), .cfg_be(cfg_be),
  .cfg_rvalid(cfg_rvalid), .host_rvalid(host_rvalid), .host_rdata(host_rdata),
  .dev_intx(dev_intx), .irq_line(irq_line)
);

// File: tb/sim_cfg_addr_xlate.sv
`timescale 1ns/1ps
module sim_cfg_addr_xlate;
  localparam int NSLOT = 4;
  localparam int SLOT0 = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic win_req = 1'b0, win_write = 1'b0;
  logic [2:0] win_off = '0;
  logic [1:0] win_size = '0;
  logic [31:0] win_wdata = '0;
  logic cfg_rvalid = 1'b0;
  logic [31:0] cfg_rdata = '0;
  logic [4*NSLOT-1:0] dev_intx = '0;
  logic [31:0] cfg_word, host_rdata, cfg_addr, cfg_wdata;
  logic host_rvalid, cfg_stb, cfg_we;
  logic [3:0] cfg_be, irq_line;

  always #2.5 clk = ~clk;

  cfg_addr_xlate #(.NSLOT(NSLOT), .SLOT0(SLOT0)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .cfg_word(cfg_word),
    .win_req(win_req), .win_write(win_write), .win_off(win_off), .win_size(win_size),
    .win_wdata(win_wdata), .host_rvalid(host_rvalid), .host_rdata(host_rdata),
    .cfg_stb(cfg_stb), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata),
    .dev_intx(dev_intx), .irq_line(irq_line));

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [32:0] ref_xlate(input logic [31:0] w, input logic [2:0] off);
    int idx = -1;
    if (w[31]) return {1'b1, w[31:2], off[1:0]};
    if (w[1:0] != 2'b00) return {1'b1, (w & ~32'h7) | {29'h0, off}};
    for (int i = 11; i <= 31; i++) if (w[i] && idx < 0) idx = i;
    if (idx < 0) return 33'h0;
    return {1'b1, (32'(idx - 11) << 11) | ({29'h0, w[10:8]} << 8) | (w & 32'hF8) | {29'h0, off}};
  endfunction

  function automatic logic [31:0] ref_swap(input logic [31:0] d, input logic [1:0] sz);
    logic [7:0] b [4];
    for (int i = 0; i < 4; i++) b[i] = d[8*i +: 8];
    if (sz == 2'b00) return {24'h0, b[0]};
    if (sz == 2'b01) return {16'h0, b[0], b[1]};
    return {b[0], b[1], b[2], b[3]};
  endfunction

  function automatic logic [3:0] ref_be(input logic [1:0] sz, input logic [2:0] off);
    if (sz == 2'b00) return 4'(1 << off[1:0]);
    if (sz == 2'b01) return off[1] ? 4'hC : 4'h3;
    return 4'hF;
  endfunction

  // reference model state
  logic [31:0] m_word = '0, m_addr = '0, m_wd = '0, m_rd = '0;
  logic        m_stb = 1'b0, m_we = 1'b0, m_rv = 1'b0;
  logic [3:0]  m_be = '0;
  logic [1:0]  m_size = '0;

  always @(posedge clk) begin
    logic [32:0] x;
    if (!rst_n) begin
      m_word = '0; m_stb = 0; m_rv = 0; m_size = '0;
    end else begin
      x = ref_xlate(m_word, win_off);
      m_stb = win_req && x[32];
      if (m_stb) begin
        m_addr = x[31:0];
        m_be   = ref_be(win_size, win_off);
        m_we   = win_write;
        m_wd   = ref_swap(win_wdata, win_size);
      end
      if (cfg_rvalid) begin
        m_rv = 1; m_rd = ref_swap(cfg_rdata, m_size);
      end else if (win_req && !win_write && !x[32]) begin
        m_rv = 1; m_rd = 32'hFFFF_FFFF;
      end else m_rv = 0;
      if (win_req) m_size = win_size;
      if (reg_wr) m_word = reg_wdata;
    end
  end

  always @(negedge clk) begin
    logic [3:0] e_irq;
    e_irq = '0;
    for (int s = 0; s < NSLOT; s++)
      for (int n = 0; n < 4; n++)
        if (dev_intx[4*s+n]) e_irq[(SLOT0+s+n)%4] = 1'b1;
    if (!rst_n) begin
      chk(cfg_word == 32'h0, "R1 reset word", cfg_word, 32'h0);
      chk(!cfg_stb && !host_rvalid, "R6 reset strobes", {30'h0, cfg_stb, host_rvalid}, 32'h0);
    end else begin
      chk(cfg_word == m_word, "R1 word", cfg_word, m_word);
      chk(cfg_stb == m_stb, "R5/R6 strobe", {31'h0, cfg_stb}, {31'h0, m_stb});
      if (m_stb && cfg_stb) begin
        chk(cfg_addr == m_addr, "R2/R3/R4 address", cfg_addr, m_addr);
        chk(cfg_we == m_we, "R6 write flag", {31'h0, cfg_we}, {31'h0, m_we});
        chk(cfg_be == m_be, "R7 byte enables", {28'h0, cfg_be}, {28'h0, m_be});
        if (m_we) chk(cfg_wdata == m_wd, "R8 write data", cfg_wdata, m_wd);
      end
      chk(host_rvalid == m_rv, "R9 read valid", {31'h0, host_rvalid}, {31'h0, m_rv});
      if (m_rv && host_rvalid) chk(host_rdata == m_rd, "R9/R5 read data", host_rdata, m_rd);
    end
    chk(irq_line == e_irq, "R10 irq lines", {28'h0, irq_line}, {28'h0, e_irq});
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic set_word(input logic [31:0] w);
    reg_wr = 1; reg_wdata = w; step(); reg_wr = 0;
  endtask

  task automatic access(input bit wr, input logic [2:0] off, input logic [1:0] sz, input logic [31:0] d);
    win_req = 1; win_write = wr; win_off = off; win_size = sz; win_wdata = d;
    step();
    win_req = 0;
  endtask

  task automatic respond(input logic [31:0] d);
    cfg_rvalid = 1; cfg_rdata = d; step(); cfg_rvalid = 0; step();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      vectors++; errors++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    repeat (4) step();
    // R2: bit 31 set, pass-through with low two bits from offset
    set_word(32'h8000_1234);
    access(1, 3'd5, 2'b00, 32'h0000_00A5); step();
    access(0, 3'd6, 2'b01, 32'h0); respond(32'h0000_BEEF);
    // R3: type bits set
    set_word(32'h0001_0A01);
    access(1, 3'd7, 2'b10, 32'h1122_3344); step();
    access(1, 3'd2, 2'b01, 32'h0000_5566); step();
    // R4: one-hot slot at bit 13, function 3
    set_word(32'h0000_23A8);
    access(1, 3'd6, 2'b00, 32'h0000_0077); step();
    access(0, 3'd0, 2'b10, 32'h0); respond(32'hDEAD_BEEF);
    // R4: two bits set, lowest wins (bit 15 -> slot 4)
    set_word(32'h4000_8000);
    access(1, 3'd4, 2'b11, 32'hCAFE_F00D); step();
    // R5: empty slot field
    set_word(32'h0000_0500);
    access(0, 3'd1, 2'b00, 32'h0); step(); step();
    access(1, 3'd0, 2'b10, 32'h9999_9999); step(); step();
    // R6: back-to-back requests, each one strobe
    set_word(32'h0000_0800);
    access(1, 3'd0, 2'b00, 32'h0000_0001);
    access(1, 3'd1, 2'b00, 32'h0000_0002);
    access(1, 3'd3, 2'b00, 32'h0000_0003); step();
    // R9: read with size 01
    access(0, 3'd2, 2'b01, 32'h0); respond(32'h0000_1357);
    // R10: interrupt patterns
    for (int p = 0; p < NSLOT * 4; p++) begin
      dev_intx = 16'(1 << p); step();
    end
    dev_intx = 16'hA5C3; step();
    dev_intx = '0; step();
    repeat (3) step();
    finish_run();
  end
endmodule